// File: doc/BRIEF.md
# Fixed-Direction GPIO with Edge Interrupts

This block is a small byte-wide GPIO peripheral with eight lines whose directions are hard-wired. The lower half of the data byte (lines 0-3) drives four output latches. The upper half (lines 4-7) samples four input pins. A host accesses it through a plain address, write-data, write-strobe and read-data bus. Reads are combinational from the address and have no side effects.

Each input passes through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one clock earlier. A per-input 2-bit edge-select field chooses falling, rising or both edges. A value of 00 masks the input. A qualifying edge sets a sticky status bit. Software clears status bits by writing ones back to them. A registered interrupt line is raised while any status bit is set.

Register offsets: 0 is direction, 1 is data, 3 is edge configuration and 4 is status. Offset 2 and offsets 5-7 are unused.

Top module: `fixdir_edge_gpio`

## Requirements
- R1: After reset, `pin_out` is 0, the configuration and status registers read 0, and `irq` is 0.
- R2: Offset 0 always reads 0x0F, where a set bit marks an output line. Writes to it change neither that value nor `pin_out`.
- R3: A write to offset 1 loads `wdata[3:0]` into the output latches. `pin_out` shows the new value after the write edge. Offset 1 bits [3:0] read back the latches.
- R4: Offset 1 bits [7:4] return `pin_in[3:0]` after two clock edges of synchronisation.
- R5: Offset 3 is a read/write register. The field for input n sits at bits [2n+1:2n].
- R6: In the field for input n, bit 0 enables falling edges and bit 1 enables rising edges. A qualifying edge on `pin_in[n]` sets status bit n, which reads as set on the third clock edge after the pin changes.
- R7: An input whose field is 00 never sets its status bit, whichever edge it sees.
- R8: Writing offset 4 clears exactly the status bits written as 1 and leaves the other bits unchanged. Status bits [7:4] read 0.
- R9: If a qualifying edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R10: `irq` is the OR of the four status bits, delayed by one clock.
- R11: Offset 2 and offsets 5-7 read 0. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register byte offset |
| wr_stb | input | 1 | Write strobe, one write per cycle it is high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 4 | Input pins (lines 4-7) |
| pin_out | output | 4 | Output latches (lines 0-3) |
| irq | output | 1 | Combined interrupt |

## Verification
A register write takes effect on the clock edge where `wr_stb` is high. The bench reads back at the following falling edge, because `rdata` is combinational from `addr`.

An input change is driven at a falling edge. It reaches the data register after two rising edges and sets status on the third. `irq` follows on the fourth. Each check samples at the falling edge just after the edge where its result is due.

The edge checks sweep every input, all four field values and both edge directions. The bench derives the expected status arithmetically from the field bits. For the collision case, the clearing write lands exactly on the third edge after the pin changes.

// File: rtl/fixdir_edge_gpio.sv
module fixdir_edge_gpio #(
  parameter int N      = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_stb,
  input  logic [2*N-1:0]    wdata,
  output logic [2*N-1:0]    rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic              irq
);
  localparam int DW = 2 * N;
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(4);

  logic [N-1:0]  out_lat, sy1, sy2, prev, sts, hit;
  logic [DW-1:0] cfg;
  logic          irq_q;

  wire wr_dat = wr_stb && addr == A_DAT;
  wire wr_cfg = wr_stb && addr == A_CFG;
  wire wr_sts = wr_stb && addr == A_STS;
  wire [N-1:0] clr = wr_sts ? wdata[N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1  <= '0;
      sy2  <= '0;
      prev <= '0;
    end else begin
      sy1  <= pin_in;
      sy2  <= sy1;
      prev <= sy2;
    end

  genvar n;
  generate
    for (n = 0; n < N; n++) begin : g_in
      wire rise = sy2[n] & ~prev[n];
      wire fall = ~sy2[n] & prev[n];
      assign hit[n] = (rise & cfg[2*n+1]) | (fall & cfg[2*n]);

      // R7
      quiet_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[n]) |-> $past(cfg[2*n+1:2*n]) != 2'b00);
      // R8
      clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata[n] && !hit[n]) |=> !sts[n]);
      // R9
      keep_on_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata[n] && hit[n]) |=> sts[n]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_lat <= '0;
      cfg     <= '0;
      sts     <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_dat) out_lat <= wdata[N-1:0];
      if (wr_cfg) cfg <= wdata;
      sts   <= (sts & ~clr) | hit;
      irq_q <= |sts;
    end

  assign pin_out = out_lat;
  assign irq     = irq_q;

  always_comb begin
    unique case (addr)
      A_DIR:   rdata = {{N{1'b0}}, {N{1'b1}}};
      A_DAT:   rdata = {sy2, out_lat};
      A_CFG:   rdata = cfg;
      A_STS:   rdata = {{N{1'b0}}, sts};
      default: rdata = '0;
    endcase
  end

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sts) |=> irq);
  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|sts) |=> !irq);
  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dat |=> $stable(pin_out));
endmodule

// File: tb/tb_fixdir_edge_gpio.sv
`timescale 1ns/1ps
module tb_fixdir_edge_gpio;
  logic       clk = 0, rst_n = 0, wr_stb = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [3:0] pin_in = 0, pin_out;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 0;

  fixdir_edge_gpio dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_stb(wr_stb),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .irq(irq));

  always #5 clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_stb = 1;
    @(posedge clk);
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1
    check("R1 pin_out", {4'h0, pin_out}, 8'h00);
    check("R1 irq", {7'h0, irq}, 8'h00);
    rd(3, 8'h00, "R1 cfg");
    rd(4, 8'h00, "R1 sts");
    // R2
    rd(0, 8'h0F, "R2 dir");
    wr(0, 8'h0F); rd(0, 8'h0F, "R2 dir after 0F");
    wr(0, 8'hF0); rd(0, 8'h0F, "R2 dir after F0");
    check("R2 pins", {4'h0, pin_out}, 8'h00);
    // R3
    for (int v = 0; v < 16; v++) begin
      wr(1, {4'hF - 4'(v), 4'(v)});
      check("R3 pin_out", {4'h0, pin_out}, 8'(v));
      rd(1, {4'h0, 4'(v)}, "R3 data read");
    end
    // R4
    @(negedge clk); pin_in = 4'hA;
    @(posedge clk);
    rd(1, {4'h0, 4'hF}, "R4 not yet");
    @(posedge clk);
    rd(1, {4'hA, 4'hF}, "R4 synced");
    @(negedge clk); pin_in = 4'h0; repeat (3) @(posedge clk);
    // R5
    for (int n = 0; n < 4; n++) begin
      wr(3, 8'h2 << (2*n)); rd(3, 8'h2 << (2*n), "R5 field");
    end
    wr(3, 8'h00); wr(4, 8'h0F);
    // R6 R7 sweep
    for (int n = 0; n < 4; n++)
      for (int m = 0; m < 4; m++)
        for (int up = 0; up < 2; up++) begin
          logic [7:0] exp;
          wr(3, 8'h00);
          @(negedge clk); pin_in[n] = (up == 0);
          repeat (4) @(posedge clk);
          wr(4, 8'h0F);
          wr(3, 8'(m) << (2*n));
          pin_in[n] = (up == 1);
          repeat (3) @(posedge clk);
          exp = (((up == 1) && m[1]) || ((up == 0) && m[0])) ? (8'h1 << n) : 8'h00;
          rd(4, exp, m == 0 ? "R7 masked" : "R6 edge");
          @(posedge clk); @(negedge clk);
          check("R10 irq", {7'h0, irq}, {7'h0, |exp});
        end
    wr(3, 8'h00); @(negedge clk); pin_in = 0; repeat (4) @(posedge clk);
    wr(4, 8'h0F);
    // R8
    wr(3, 8'hFF);
    @(negedge clk); pin_in = 4'hF; repeat (4) @(posedge clk);
    rd(4, 8'h0F, "R8 all set");
    wr(4, 8'hF5); rd(4, 8'h0A, "R8 partial clear");
    @(posedge clk); @(negedge clk);
    check("R10 irq held", {7'h0, irq}, 8'h01);
    wr(4, 8'h0A); rd(4, 8'h00, "R8 cleared");
    @(posedge clk); @(negedge clk);
    check("R10 irq low", {7'h0, irq}, 8'h00);
    // R9
    @(negedge clk); pin_in[0] = 0;
    @(posedge clk); @(posedge clk);
    wr(4, 8'h01);
    rd(4, 8'h01, "R9 collision kept");
    wr(4, 8'h01); rd(4, 8'h00, "R9 later clear");
    // R11
    wr(3, 8'h5A); wr(1, 8'h03);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF); rd(3'(a), 8'h00, "R11 unused read");
    end
    wr(2, 8'hFF); rd(2, 8'h00, "R11 offset2");
    rd(3, 8'h5A, "R11 cfg intact");
    check("R11 pins intact", {4'h0, pin_out}, 8'h03);
    rd(4, 8'h00, "R11 sts intact");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule